// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one small write-back cache coherent with its peers on a shared snooping bus. Every line holds one of four states: Invalid, Shared, Exclusive (the only copy, clean) or Modified (the only copy, dirty). A processor port accepts one read, write or replace request at a time and holds it stalled until any bus work it needs has finished. A bus port asks an external arbiter for the bus and then issues read, read-for-ownership and write-back transactions. A snoop port watches the transactions of the other caches, votes on a wired-OR shared line and flushes data when its copy has to supply the bus.

A read miss samples the shared line to choose between Exclusive and Shared, so a line that no other cache holds can later be written with no bus traffic at all. When several caches hold a clean copy, an external fixed-priority rule raises the supply input on exactly one of them, and only that one places data on the bus. The data array is a small register array indexed directly by the low address bits.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid and cpu_done_o, bus_req_o, bus_cmd_o, bus_addr_o, bus_dvalid_o and bus_shared_o are all zero.
- R2: Addresses are {tag, index} with the index in the low IDX_W bits. A read (cpu_op_i 0, and code 3, which acts as a read) that misses issues bus command 1 (read) with the full address. The line becomes Exclusive if bus_shared_i is low in the cycle after the address cycle and Shared if it is high, and the fill data is returned on cpu_rdata_o. A read hit in any valid state completes with no bus command.
- R3: For a snooped command 1 (read) that hits a valid line, bus_shared_o is high in the cycle after snp_valid_i. Snooped codes 0 and 3 cause no vote, no data and no state change.
- R4: A write (cpu_op_i 1) that hits an Exclusive or Modified line completes with no bus command and leaves the line Modified with the new data.
- R5: A write that hits a Shared line or misses issues bus command 2 (read-for-ownership), and the line becomes Modified holding the write data; cpu_rdata_o returns the write data.
- R6: A snooped read that hits a Modified line drives bus_dvalid_o with the line data in the next cycle and moves the line to Shared; a hit on an Exclusive line also moves it to Shared.
- R7: A snooped command 2 (read-for-ownership) that hits invalidates the line in any valid state; a Modified line is flushed on bus_dvalid_o in the next cycle first.
- R8: A snooped read or read-for-ownership that hits a clean line places its data on the bus only when snp_supply_i is high in the snoop cycle.
- R9: A replace (cpu_op_i 2) of a Modified line issues bus command 3 (write-back) with the line data in the cycle after the command and leaves the line Invalid; a replace of a clean line drops it with no bus command; a replace that misses does nothing.
- R10: A read or write that misses on an index holding a Modified line of another tag first writes that line back (command 3, old tag) and then issues its own read or read-for-ownership.
- R11: One request is outstanding at a time; cpu_done_o is a one-cycle pulse per request, and the bus command is chosen when the grant arrives, so a snoop taken while waiting for the bus changes it (a pending replace whose line was invalidated finishes with no write-back).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until cpu_done_o |
| cpu_op_i | input | 2 | 0 read, 1 write, 2 replace, 3 read |
| cpu_addr_i | input | ADDR_W | Request address {tag, index} |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_done_o | output | 1 | Request complete (one cycle) |
| cpu_rdata_o | output | DATA_W | Read or written data, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant (level) |
| bus_cmd_o | output | 2 | Own command: 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr_o | output | ADDR_W | Own command address |
| bus_dvalid_o | output | 1 | This cache drives data (flush or write-back) |
| bus_data_o | output | DATA_W | Data driven onto the bus |
| bus_fill_i | input | DATA_W | Fill data in the cycle after own address |
| bus_shared_i | input | 1 | Wired-OR shared line as seen by this cache |
| bus_shared_o | output | 1 | This cache's vote on the shared line |
| snp_valid_i | input | 1 | Another cache's command is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same codes as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_supply_i | input | 1 | This cache is the chosen clean supplier |

## Verification
The bench chases the Exclusive-versus-Shared choice by sampling different shared-line values and then writing the line: a design that read the shared line in the wrong cycle or ignored it would issue a needless read-for-ownership or skip a required one. It writes to Shared hits, which a design treating any hit as local would complete silently, and evicts dirty lines through conflict misses, which a design without the victim write-back would lose. It snoops clean lines with and without the supply input and with unused command codes, so a design flushing on every clean hit or reacting to code 3 puts stray data on the bus. A replace left waiting for the grant while a snooped read-for-ownership invalidates its line catches a design that fixes its command at request time and writes back stale data.

// File: rtl/coh_pkg.sv
// Shared types and the request planning rule for the coherence controller.
// Assumes one line per index (direct mapped) and whole-line writes.
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_t;

    localparam logic [1:0] OP_RD  = 2'd0;
    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_RPL = 2'd2;

    // Bus command a request needs given the current line state and tag match.
    function automatic bus_cmd_t plan_cmd(input logic [1:0] op,
                                          input line_st_t st,
                                          input logic tag_eq);
        logic hit;
        hit = (st != LS_INV) && tag_eq;
        if (op == OP_RPL) begin
            return (hit && st == LS_MOD) ? BC_WB : BC_NONE;
        end
        if (op == OP_WR) begin
            if (hit && (st == LS_EXC || st == LS_MOD)) return BC_NONE;
            if (!hit && st == LS_MOD) return BC_WB;
            return BC_RDX;
        end
        if (hit) return BC_NONE;
        if (st == LS_MOD) return BC_WB;
        return BC_RD;
    endfunction

endpackage

// File: rtl/coh_line_array.sv
// Per-line state, tag and data registers with two read ports (processor,
// snoop) and one write path. Assumes the snoop and request sides never
// write in the same cycle; the snoop write wins if they ever do.
module coh_line_array
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output line_st_t          st_a,
    output logic [TAG_W-1:0]  tag_a,
    output logic [DATA_W-1:0] dat_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output line_st_t          st_b,
    output logic [TAG_W-1:0]  tag_b,
    output logic [DATA_W-1:0] dat_b,
    input  logic              snp_we,
    input  line_st_t          snp_st,
    input  logic              req_we,
    input  line_st_t          req_st,
    input  logic              req_load,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_dat
);
    localparam int LINES = 1 << IDX_W;

    line_st_t          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Update one line from the snoop side or the request side.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end else if (snp_we && rd_idx_b == IDX_W'(i)) begin
                st_q[i] <= snp_st;
            end else if (req_we && rd_idx_a == IDX_W'(i)) begin
                st_q[i] <= req_st;
                if (req_load) begin
                    tag_q[i] <= req_tag;
                    dat_q[i] <= req_dat;
                end
            end
        end
    end

    // Read ports.
    assign st_a  = st_q[rd_idx_a];
    assign tag_a = tag_q[rd_idx_a];
    assign dat_a = dat_q[rd_idx_a];
    assign st_b  = st_q[rd_idx_b];
    assign tag_b = tag_q[rd_idx_b];
    assign dat_b = dat_q[rd_idx_b];

endmodule

// File: rtl/coh_snoop_resp.sv
// Snoop side: decides the shared vote, the flush and the state change for a
// command issued by another cache. Vote and flush appear one cycle after the
// snooped address. Assumes no snoop arrives while this cache owns the bus.
module coh_snoop_resp
    import coh_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [TAG_W-1:0]  snp_tag_i,
    input  logic              snp_supply_i,
    input  line_st_t          ln_st_i,
    input  logic [TAG_W-1:0]  ln_tag_i,
    input  logic [DATA_W-1:0] ln_dat_i,
    output logic              upd_en_o,
    output line_st_t          upd_st_o,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_data_o
);
    logic hit, is_rd, is_rdx, give_data;

    // Hit detection and the next line state for a snooped command.
    always_comb begin
        hit       = snp_valid_i && (ln_st_i != LS_INV) && (ln_tag_i == snp_tag_i);
        is_rd     = (snp_cmd_i == BC_RD);
        is_rdx    = (snp_cmd_i == BC_RDX);
        upd_en_o  = hit && (is_rd || is_rdx);
        upd_st_o  = is_rdx ? LS_INV : LS_SHR;
        give_data = upd_en_o && ((ln_st_i == LS_MOD) || snp_supply_i);
    end

    // Register the vote and the flush for the cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_o     <= 1'b0;
            flush_o      <= 1'b0;
            flush_data_o <= '0;
        end else begin
            shared_o     <= hit && is_rd;
            flush_o      <= give_data;
            flush_data_o <= ln_dat_i;
        end
    end

endmodule

// File: rtl/coh_req_fsm.sv
// Request side: completes hits locally, otherwise requests the bus, picks
// the command when granted, runs address and data cycles, and writes the
// line. One request at a time; the request must be held until done.
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req_i,
    input  logic [1:0]              cpu_op_i,
    input  logic [TAG_W+IDX_W-1:0]  cpu_addr_i,
    input  logic [DATA_W-1:0]       cpu_wdata_i,
    output logic                    cpu_done_o,
    output logic [DATA_W-1:0]       cpu_rdata_o,
    input  logic                    snp_busy_i,
    output logic                    bus_req_o,
    input  logic                    bus_gnt_i,
    output logic [1:0]              bus_cmd_o,
    output logic [TAG_W+IDX_W-1:0]  bus_addr_o,
    input  logic                    bus_shared_i,
    input  logic [DATA_W-1:0]       bus_fill_i,
    output logic                    wb_valid_o,
    input  line_st_t                ln_st_i,
    input  logic [TAG_W-1:0]        ln_tag_i,
    input  logic [DATA_W-1:0]       ln_dat_i,
    output logic                    wr_en_o,
    output line_st_t                wr_st_o,
    output logic                    wr_load_o,
    output logic [TAG_W-1:0]        wr_tag_o,
    output logic [DATA_W-1:0]       wr_dat_o
);
    localparam int ADDR_W = TAG_W + IDX_W;

    typedef enum logic [2:0] {F_IDLE, F_ARB, F_ADDR, F_DATA, F_RESP} fsm_t;

    fsm_t              state_q, state_d;
    bus_cmd_t          cmd_q, cmd_d, plan;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  cpu_idx;

    assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
    assign cpu_idx = cpu_addr_i[IDX_W-1:0];

    // Next state, command choice and line write for the current request.
    always_comb begin
        state_d   = state_q;
        cmd_d     = cmd_q;
        addr_d    = addr_q;
        rdata_d   = rdata_q;
        wr_en_o   = 1'b0;
        wr_st_o   = LS_INV;
        wr_load_o = 1'b0;
        wr_tag_o  = cpu_tag;
        wr_dat_o  = cpu_wdata_i;
        plan      = plan_cmd(cpu_op_i, ln_st_i, ln_tag_i == cpu_tag);
        unique case (state_q)
            F_IDLE: begin
                if (cpu_req_i && !snp_busy_i) begin
                    if (plan == BC_NONE) begin
                        state_d = F_RESP;
                        rdata_d = ln_dat_i;
                        if (cpu_op_i == OP_WR) begin
                            wr_en_o   = 1'b1;
                            wr_st_o   = LS_MOD;
                            wr_load_o = 1'b1;
                            rdata_d   = cpu_wdata_i;
                        end else if (cpu_op_i == OP_RPL && ln_st_i != LS_INV
                                     && ln_tag_i == cpu_tag) begin
                            wr_en_o = 1'b1;
                            wr_st_o = LS_INV;
                        end
                    end else begin
                        state_d = F_ARB;
                    end
                end
            end
            F_ARB: begin
                if (bus_gnt_i) begin
                    if (plan == BC_NONE) begin
                        state_d = F_IDLE;
                    end else begin
                        cmd_d   = plan;
                        addr_d  = (plan == BC_WB) ? {ln_tag_i, cpu_idx} : cpu_addr_i;
                        state_d = F_ADDR;
                    end
                end
            end
            F_ADDR: state_d = F_DATA;
            F_DATA: begin
                wr_en_o = 1'b1;
                unique case (cmd_q)
                    BC_WB: begin
                        wr_st_o = LS_INV;
                        state_d = F_IDLE;
                    end
                    BC_RD: begin
                        wr_st_o   = bus_shared_i ? LS_SHR : LS_EXC;
                        wr_load_o = 1'b1;
                        wr_dat_o  = bus_fill_i;
                        rdata_d   = bus_fill_i;
                        state_d   = F_RESP;
                    end
                    default: begin
                        wr_st_o   = LS_MOD;
                        wr_load_o = 1'b1;
                        rdata_d   = cpu_wdata_i;
                        state_d   = F_RESP;
                    end
                endcase
            end
            F_RESP:  state_d = F_IDLE;
            default: state_d = F_IDLE;
        endcase
    end

    // Sequence registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            cmd_q   <= BC_NONE;
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            rdata_q <= rdata_d;
        end
    end

    // Port decode from the sequence state.
    assign cpu_done_o  = (state_q == F_RESP);
    assign cpu_rdata_o = rdata_q;
    assign bus_req_o   = (state_q == F_ARB) || (state_q == F_ADDR) || (state_q == F_DATA);
    assign bus_cmd_o   = (state_q == F_ADDR) ? cmd_q : BC_NONE;
    assign bus_addr_o  = (state_q == F_ADDR) ? addr_q : '0;
    assign wb_valid_o  = (state_q == F_DATA) && (cmd_q == BC_WB);

endmodule

// File: rtl/coh_cache_ctrl.sv
// Top of the snooping MESI controller: joins the line array, the request
// sequencer and the snoop responder. Assumes an external arbiter, an
// external wired-OR of the shared votes and an external supplier choice.
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic [1:0]        cpu_op_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_done_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_dvalid_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic [DATA_W-1:0] bus_fill_i,
    input  logic              bus_shared_i,
    output logic              bus_shared_o,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              snp_supply_i
);
    line_st_t          st_a, st_b, snp_st, req_st;
    logic [TAG_W-1:0]  tag_a, tag_b, req_tag;
    logic [DATA_W-1:0] dat_a, dat_b, req_dat, flush_data;
    logic              snp_we, req_we, req_load, flush_v, wb_v;

    coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (cpu_addr_i[IDX_W-1:0]),
        .st_a     (st_a),
        .tag_a    (tag_a),
        .dat_a    (dat_a),
        .rd_idx_b (snp_addr_i[IDX_W-1:0]),
        .st_b     (st_b),
        .tag_b    (tag_b),
        .dat_b    (dat_b),
        .snp_we   (snp_we),
        .snp_st   (snp_st),
        .req_we   (req_we),
        .req_st   (req_st),
        .req_load (req_load),
        .req_tag  (req_tag),
        .req_dat  (req_dat)
    );

    coh_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req_i    (cpu_req_i),
        .cpu_op_i     (cpu_op_i),
        .cpu_addr_i   (cpu_addr_i),
        .cpu_wdata_i  (cpu_wdata_i),
        .cpu_done_o   (cpu_done_o),
        .cpu_rdata_o  (cpu_rdata_o),
        .snp_busy_i   (snp_valid_i),
        .bus_req_o    (bus_req_o),
        .bus_gnt_i    (bus_gnt_i),
        .bus_cmd_o    (bus_cmd_o),
        .bus_addr_o   (bus_addr_o),
        .bus_shared_i (bus_shared_i),
        .bus_fill_i   (bus_fill_i),
        .wb_valid_o   (wb_v),
        .ln_st_i      (st_a),
        .ln_tag_i     (tag_a),
        .ln_dat_i     (dat_a),
        .wr_en_o      (req_we),
        .wr_st_o      (req_st),
        .wr_load_o    (req_load),
        .wr_tag_o     (req_tag),
        .wr_dat_o     (req_dat)
    );

    coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .clk          (clk),
        .rst_n        (rst_n),
        .snp_valid_i  (snp_valid_i),
        .snp_cmd_i    (snp_cmd_i),
        .snp_tag_i    (snp_addr_i[ADDR_W-1:IDX_W]),
        .snp_supply_i (snp_supply_i),
        .ln_st_i      (st_b),
        .ln_tag_i     (tag_b),
        .ln_dat_i     (dat_b),
        .upd_en_o     (snp_we),
        .upd_st_o     (snp_st),
        .shared_o     (bus_shared_o),
        .flush_o      (flush_v),
        .flush_data_o (flush_data)
    );

    // Bus data source: own write-back or a snoop flush (never both).
    assign bus_dvalid_o = wb_v | flush_v;
    assign bus_data_o   = wb_v ? dat_a : flush_data;

endmodule

// File: rtl/coh_cache_ctrl_chk.sv
// Protocol checker for coh_cache_ctrl, attached with bind.
module coh_cache_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req_i,
    input logic       cpu_done_o,
    input logic       bus_req_o,
    input logic       bus_gnt_i,
    input logic [1:0] bus_cmd_o,
    input logic       bus_dvalid_o,
    input logic       bus_shared_o,
    input logic       snp_valid_i,
    input logic [1:0] snp_cmd_i
);
    // R5: an own command only follows a granted request.
    assert_cmd_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'd0) |-> ($past(bus_gnt_i) && $past(bus_req_o) && bus_req_o));

    // R3: the shared vote only follows a snooped read.
    assert_vote_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_shared_o |-> ($past(snp_valid_i) && $past(snp_cmd_i) == 2'd1));

    // R11: completion is a single-cycle pulse of a held request.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done_o |=> !cpu_done_o);

    assert_done_held_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done_o |-> $past(cpu_req_i));

    // R7: bus data comes only after a snoop or after an own write-back.
    assert_data_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dvalid_o |-> ($past(snp_valid_i) || $past(bus_cmd_o) == 2'd3));

    // R9: a write-back command carries data in the next cycle.
    assert_wb_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 2'd3) |=> bus_dvalid_o);

endmodule

bind coh_cache_ctrl coh_cache_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req_i    (cpu_req_i),
    .cpu_done_o   (cpu_done_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_cmd_o    (bus_cmd_o),
    .bus_dvalid_o (bus_dvalid_o),
    .bus_shared_o (bus_shared_o),
    .snp_valid_i  (snp_valid_i),
    .snp_cmd_i    (snp_cmd_i)
);

// File: tb/sim_coh_cache_ctrl.sv
`timescale 1ns/1ps
module sim_coh_cache_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic       bus_gnt = 1'b0;
    logic [1:0] bus_cmd;
    logic [5:0] bus_addr;
    logic       bus_dvalid;
    logic [7:0] bus_data;
    logic [7:0] fill_drv = '0;
    logic       sh_drv = 1'b0;
    logic       shared_o;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic [5:0] snp_addr = '0;
    logic       snp_sup = 1'b0;

    int errors = 0;
    int checks = 0;
    int gdelay = 0;
    int gcnt = 0;

    int         m_st  [4];
    logic [3:0] m_tag [4];
    logic [7:0] m_dat [4];

    always #2 clk = ~clk;

    coh_cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_op_i(cpu_op), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
        .bus_addr_o(bus_addr), .bus_dvalid_o(bus_dvalid), .bus_data_o(bus_data),
        .bus_fill_i(fill_drv), .bus_shared_i(sh_drv), .bus_shared_o(shared_o),
        .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .snp_supply_i(snp_sup)
    );

    // Arbiter model: grant after gdelay cycles of request, drop with request.
    always @(negedge clk) begin
        if (!bus_req) begin
            gcnt = 0;
            bus_gnt = 1'b0;
        end else begin
            if (gcnt >= gdelay) bus_gnt = 1'b1;
            gcnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
        end
    endtask

    // Processor request with an expected result computed from the model.
    task automatic do_cpu(input logic [1:0] op, input logic [5:0] addr,
                          input logic [7:0] wd, input logic sh,
                          input logic [7:0] fill, input int gd);
        int n_cmd = 0;
        logic [1:0] cmds [4];
        logic [5:0] adrs [4];
        logic [7:0] wbd = '0;
        logic saw_wb = 1'b0;
        logic prev_wb = 1'b0;
        logic done = 1'b0;
        logic [7:0] rd = '0;
        int cyc = 0;
        int e_n = 0;
        logic [1:0] e_cmd [2];
        logic [5:0] e_adr [2];
        logic [7:0] e_wb = '0;
        logic [7:0] e_rd = '0;
        string tagn;
        int i;
        logic [3:0] t;
        bit hit, ok;
        gdelay = gd;
        sh_drv = sh;
        fill_drv = fill;
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = op; cpu_addr = addr; cpu_wdata = wd;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (prev_wb && bus_dvalid) begin wbd = bus_data; saw_wb = 1'b1; end
            prev_wb = (bus_cmd == 2'd3);
            if (bus_cmd != 2'd0 && n_cmd < 4) begin
                cmds[n_cmd] = bus_cmd; adrs[n_cmd] = bus_addr; n_cmd++;
            end
            if (cpu_done) begin done = 1'b1; rd = cpu_rdata; cpu_req = 1'b0; end
        end
        check(done, "R11", "request completion", done ? "done" : "hung", "done");
        @(negedge clk);
        check(!cpu_done, "R11", "done pulse width", $sformatf("%0b", cpu_done), "0");
        // Expected outcome from the model state at completion time.
        i = int'(addr[1:0]);
        t = addr[5:2];
        hit = (m_st[i] != 0) && (m_tag[i] == t);
        if (op == 2'd2) begin
            tagn = "R9";
            if (hit && m_st[i] == 3) begin
                e_cmd[0] = 2'd3; e_adr[0] = addr; e_wb = m_dat[i]; e_n = 1;
            end
            if (hit) m_st[i] = 0;
        end else begin
            if (!hit && m_st[i] == 3) begin
                e_cmd[0] = 2'd3; e_adr[0] = {m_tag[i], addr[1:0]}; e_wb = m_dat[i];
                e_n = 1; m_st[i] = 0;
            end
            if (op == 2'd1) begin
                if (hit && m_st[i] >= 2) tagn = "R4";
                else begin
                    tagn = (e_n == 1) ? "R10" : "R5";
                    e_cmd[e_n] = 2'd2; e_adr[e_n] = addr; e_n++;
                end
                m_st[i] = 3; m_tag[i] = t; m_dat[i] = wd; e_rd = wd;
            end else if (hit) begin
                tagn = "R2"; e_rd = m_dat[i];
            end else begin
                tagn = (e_n == 1) ? "R10" : "R2";
                e_cmd[e_n] = 2'd1; e_adr[e_n] = addr; e_n++;
                m_st[i] = sh ? 1 : 2; m_tag[i] = t; m_dat[i] = fill; e_rd = fill;
            end
        end
        ok = (n_cmd == e_n);
        for (int k = 0; k < e_n && k < n_cmd; k++)
            if (cmds[k] != e_cmd[k] || adrs[k] != e_adr[k]) ok = 0;
        check(ok, tagn, $sformatf("bus commands op=%0d addr=%h", op, addr),
              $sformatf("n=%0d first=%0d@%h", n_cmd, n_cmd > 0 ? cmds[0] : 2'd0,
                        n_cmd > 0 ? adrs[0] : 6'd0),
              $sformatf("n=%0d first=%0d@%h", e_n, e_n > 0 ? e_cmd[0] : 2'd0,
                        e_n > 0 ? e_adr[0] : 6'd0));
        if (e_n > 0 && e_cmd[0] == 2'd3)
            check(saw_wb && wbd == e_wb, tagn, "write-back data",
                  $sformatf("%h", wbd), $sformatf("%h", e_wb));
        if (op != 2'd2)
            check(rd == e_rd, tagn, "returned data",
                  $sformatf("%h", rd), $sformatf("%h", e_rd));
    endtask

    // Snooped command from another cache, checked one cycle later.
    task automatic do_snoop(input logic [1:0] cmd, input logic [5:0] addr,
                            input logic sup);
        int i;
        bit hit, e_sh, e_fl;
        string tagn;
        i = int'(addr[1:0]);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr; snp_sup = sup;
        hit  = (m_st[i] != 0) && (m_tag[i] == addr[5:2]);
        e_sh = hit && cmd == 2'd1;
        e_fl = hit && (cmd == 2'd1 || cmd == 2'd2) && (m_st[i] == 3 || sup);
        if (cmd == 2'd2) tagn = "R7";
        else if (cmd == 2'd1 && hit && m_st[i] >= 2) tagn = "R6";
        else if (cmd == 2'd1 && hit && sup) tagn = "R8";
        else tagn = "R3";
        @(negedge clk);
        snp_valid = 1'b0;
        check(shared_o == e_sh, tagn, $sformatf("shared vote cmd=%0d", cmd),
              $sformatf("%0b", shared_o), $sformatf("%0b", e_sh));
        check(bus_dvalid == e_fl && (!e_fl || bus_data == m_dat[i]), tagn,
              $sformatf("flush cmd=%0d sup=%0b", cmd, sup),
              $sformatf("%0b/%h", bus_dvalid, bus_data),
              $sformatf("%0b/%h", e_fl, m_dat[i]));
        if (hit && cmd == 2'd1) m_st[i] = 1;
        if (hit && cmd == 2'd2) m_st[i] = 0;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = '0; m_dat[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_done && !bus_req && bus_cmd == 0 && bus_addr == 0 && !bus_dvalid
              && !shared_o, "R1", "outputs after reset",
              $sformatf("%0b%0b%0d%0b%0b", cpu_done, bus_req, bus_cmd, bus_dvalid, shared_o),
              "00000");
        // Directed corner cases.
        do_cpu(2'd0, 6'h05, 8'h00, 1'b0, 8'hA1, 0);   // R2 miss, no sharer -> E
        do_cpu(2'd1, 6'h05, 8'hB2, 1'b0, 8'h00, 0);   // R4 E write is local
        do_snoop(2'd1, 6'h05, 1'b0);                  // R6 M flushes, -> S
        do_cpu(2'd1, 6'h05, 8'hC3, 1'b0, 8'h00, 1);   // R5 S write needs RDX
        do_snoop(2'd3, 6'h05, 1'b1);                  // R3 code 3 ignored
        do_cpu(2'd1, 6'h05, 8'hC4, 1'b0, 8'h00, 0);   // R4 still M
        do_cpu(2'd3, 6'h06, 8'h00, 1'b1, 8'hD5, 2);   // R2 code 3 reads, sharer -> S
        do_snoop(2'd1, 6'h06, 1'b1);                  // R8 clean supplier
        do_snoop(2'd1, 6'h06, 1'b0);                  // R3 vote, no data
        do_cpu(2'd1, 6'h15, 8'hE6, 1'b0, 8'h00, 0);   // R10 victim write-back
        do_snoop(2'd2, 6'h15, 1'b0);                  // R7 RDX on M flushes, -> I
        do_cpu(2'd0, 6'h15, 8'h00, 1'b0, 8'h17, 0);   // R2 -> E
        do_cpu(2'd2, 6'h15, 8'h00, 1'b0, 8'h00, 0);   // R9 clean replace
        do_cpu(2'd2, 6'h15, 8'h00, 1'b0, 8'h00, 0);   // R9 replace miss
        do_cpu(2'd1, 6'h15, 8'h28, 1'b0, 8'h00, 0);   // R5 miss write
        do_cpu(2'd2, 6'h15, 8'h00, 1'b0, 8'h00, 3);   // R9 dirty replace
        do_cpu(2'd0, 6'h0b, 8'h00, 1'b0, 8'h39, 0);
        do_cpu(2'd1, 6'h0b, 8'h4A, 1'b0, 8'h00, 0);
        // R11: snoop while the replace waits for the grant removes the write-back.
        fork
            do_cpu(2'd2, 6'h0b, 8'h00, 1'b0, 8'h00, 8);
            begin
                repeat (2) @(negedge clk);
                do_snoop(2'd2, 6'h0b, 1'b0);
            end
        join
        // Constrained random mix.
        for (int k = 0; k < 400; k++) begin
            logic [5:0] a;
            a = {4'($urandom % 3), 2'($urandom % 4)};
            if ($urandom % 10 < 3)
                do_snoop(2'($urandom % 4), a, 1'($urandom % 2));
            else
                do_cpu(2'($urandom % 4), a, 8'($urandom), 1'($urandom % 2),
                       8'($urandom), int'($urandom % 4));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule